// File: doc/BRIEF.md
# Block-Write Configuration Register Slave (two-wire serial)

This block is a two-wire serial bus slave that owns a 21-byte configuration register file and presents every byte of it in parallel to the surrounding logic. The bus lines are sampled on a fast system clock, at least eight times the serial clock rate. Bus activity is found from the sampled levels: START and STOP are SDA edges while SCL is high. The slave answers a single fixed 7-bit device address. The write form of the address byte is 0xD2 and the read form is 0xD3.

A write always uses the block form. After the address the master sends two header bytes. The slave acknowledges both and throws them away. Every later data byte lands in the next register, starting at register 0 and counting up, until STOP. Two register pairs, 11/12 and 13/14, are staged in shadow storage. A pair reaches the live file at STOP only when both of its bytes arrived in that transaction. A read first returns the readback count held in register 8 and then registers 0 upward. It ends when the master answers with NACK or when the count runs out.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the register file holds 0x08 in register 8, 0x10 in register 9, 0xFF in registers 1 to 5, 15 and 16, 0x07 in register 6 and 0x00 in all other registers. Register i appears on cfg_o bits [8i+7:8i]. sda_oe_o is low.
- R2: An address byte of 0xD2 or 0xD3 is acknowledged by driving SDA low in the ninth clock. Any other address gets no acknowledge, and the bytes that follow it up to the next START change no register.
- R3: In a write, the two bytes after the address are acknowledged and their values are ignored. Data byte k then goes to register k, and registers outside the two pairs take the new value before STOP.
- R4: Write data bytes past register 20 are acknowledged and discarded. No register is written a second time within that transaction.
- R5: Registers 11 and 12 change only at STOP, and only when both were written in that transaction. Otherwise neither changes.
- R6: Registers 13 and 14 follow the same all-or-nothing rule at STOP.
- R7: A write of 0x00 to register 8 is ignored and the register keeps its previous value.
- R8: A read sends the value of register 8 first and then registers 0, 1, 2 and so on, most significant bit first.
- R9: After min(register 8, 21) register bytes the slave stops driving SDA, even if the master acknowledges the last byte.
- R10: A NACK from the master ends the read, and SDA stays released for the rest of the transaction.
- R11: sda_oe_o changes only while SCL is low, and it is low in the cycle after a STOP is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_o | output | 168 | Live register file, register i at bits [8i+7:8i] |

## Verification
Writes are run in three forms: a full block that runs past the last register, a block that stops partway through the second pair, and a block whose ninth byte is zero. Together they separate ascending loading, discard past the end, pair atomicity and the zero-count guard. A bus transaction to a foreign address shows whether address decode blocks writes. Reads are run with a short count and master ACK to the end, with an early NACK, and with a count above the file size. These show whether the slave releases SDA on count exhaustion, on NACK, or only at the clamp. A behavioural model of the register file is compared with cfg_o on every clock between transactions.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_HDR,
        PH_DATA
    } rx_phase_e;

    // Power-on value of each configuration byte.
    function automatic logic [7:0] reg_default(input int idx);
        logic [7:0] v;
        v = 8'h00;
        if (idx >= 1 && idx <= 5) v = 8'hFF;
        if (idx == 6)             v = 8'h07;
        if (idx == 8)             v = 8'h08;
        if (idx == 9)             v = 8'h10;
        if (idx == 15 || idx == 16) v = 8'hFF;
        return v;
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // stage 0 and 1 synchronise, stage 2 keeps the previous synced value
    localparam int DEPTH = 3;

    typedef struct packed {
        logic [DEPTH-1:0] scl_p;
        logic [DEPTH-1:0] sda_p;
    } smp_t;

    smp_t q, n;

    always_comb begin
        n       = q;
        n.scl_p = {q.scl_p[DEPTH-2:0], scl_i};
        n.sda_p = {q.sda_p[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= n;
    end

    assign scl_lvl_o  = q.scl_p[1];
    assign sda_lvl_o  = q.sda_p[1];
    assign scl_rise_o = q.scl_p[1] & ~q.scl_p[2];
    assign scl_fall_o = ~q.scl_p[1] & q.scl_p[2];
    assign start_o    = q.scl_p[1] & q.scl_p[2] & q.sda_p[2] & ~q.sda_p[1];
    assign stop_o     = q.scl_p[1] & q.scl_p[2] & ~q.sda_p[2] & q.sda_p[1];

endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store #(
    parameter int NREG     = 21,
    parameter int IDX_W    = 5,
    parameter int CNT_IDX  = 8,
    parameter int PAIR0_LO = 11,
    parameter int PAIR1_LO = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [7:0]        wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [7:0]        rd_data_o,
    output logic [7:0]        cnt_val_o,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int NPAIR = 2;
    localparam int PAIR_LO [NPAIR] = '{PAIR0_LO, PAIR1_LO};

    typedef struct packed {
        logic [NREG-1:0][7:0]         regs;
        logic [NPAIR-1:0][1:0][7:0]   shadow;
        logic [NPAIR-1:0][1:0]        pend;
    } store_t;

    store_t q, n;
    logic   hit_pair;

    always_comb begin
        n        = q;
        hit_pair = 1'b0;
        if (start_i) n.pend = '0;
        if (wr_en_i && int'(wr_idx_i) < NREG) begin
            for (int p = 0; p < NPAIR; p++) begin
                for (int h = 0; h < 2; h++) begin
                    if (int'(wr_idx_i) == PAIR_LO[p] + h) begin
                        n.shadow[p][h] = wr_data_i;
                        n.pend[p][h]   = 1'b1;
                        hit_pair       = 1'b1;
                    end
                end
            end
            if (!hit_pair && !(int'(wr_idx_i) == CNT_IDX && wr_data_i == 8'h00))
                n.regs[wr_idx_i] = wr_data_i;
        end
        if (stop_i) begin
            for (int p = 0; p < NPAIR; p++) begin
                if (q.pend[p] == 2'b11) begin
                    n.regs[PAIR_LO[p]]     = q.shadow[p][0];
                    n.regs[PAIR_LO[p] + 1] = q.shadow[p][1];
                end
            end
            n.pend = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.shadow <= '0;
            q.pend   <= '0;
            for (int i = 0; i < NREG; i++) q.regs[i] <= cfg_i2c_pkg::reg_default(i);
        end else begin
            q <= n;
        end
    end

    assign rd_data_o = (int'(rd_idx_i) < NREG) ? q.regs[rd_idx_i] : 8'h00;
    assign cnt_val_o = q.regs[CNT_IDX];
    assign cfg_o     = q.regs;

endmodule

// File: rtl/i2c_blk_engine.sv
module i2c_blk_engine
    import cfg_i2c_pkg::*;
#(
    parameter int         NREG     = 21,
    parameter int         IDX_W    = 5,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             sda_lvl_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [7:0]       cnt_val_i,
    input  logic [7:0]       rd_data_i,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic             sda_oe_o
);
    typedef struct packed {
        eng_state_e       state;
        rx_phase_e        phase;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic             rw;
        logic             hdr_cnt;
        logic [IDX_W-1:0] idx;
        logic [7:0]       txbyte;
        logic             oe;
        logic             ackd;
    } eng_t;

    eng_t       q, n;
    logic       wr_en;
    logic [7:0] lim;

    always_comb begin
        n     = q;
        wr_en = 1'b0;
        lim   = (int'(cnt_val_i) > NREG) ? 8'(NREG) : cnt_val_i;
        if (stop_i) begin
            n.state = S_IDLE;
            n.oe    = 1'b0;
        end else if (start_i) begin
            n.state  = S_RX;
            n.phase  = PH_ADDR;
            n.bitcnt = '0;
            n.oe     = 1'b0;
        end else begin
            unique case (q.state)
                S_RX: begin
                    if (scl_rise_i && q.bitcnt != 4'd8) begin
                        n.shreg  = {q.shreg[6:0], sda_lvl_i};
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall_i && q.bitcnt == 4'd8) begin
                        n.state = S_RX_ACK;
                        n.oe    = 1'b1;
                        case (q.phase)
                            PH_ADDR: begin
                                if (q.shreg[7:1] == DEV_ADDR) begin
                                    n.rw      = q.shreg[0];
                                    n.phase   = q.shreg[0] ? PH_DATA : PH_HDR;
                                    n.hdr_cnt = 1'b0;
                                    n.idx     = '0;
                                end else begin
                                    n.state = S_IDLE;
                                    n.oe    = 1'b0;
                                end
                            end
                            PH_HDR: begin
                                if (q.hdr_cnt) begin
                                    n.phase = PH_DATA;
                                    n.idx   = '0;
                                end
                                n.hdr_cnt = 1'b1;
                            end
                            default: begin
                                if (int'(q.idx) < NREG) begin
                                    wr_en = 1'b1;
                                    n.idx = q.idx + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall_i) begin
                        n.bitcnt = '0;
                        if (q.rw) begin
                            n.state  = S_TX;
                            n.txbyte = cnt_val_i;
                            n.oe     = ~cnt_val_i[7];
                        end else begin
                            n.state = S_RX;
                            n.oe    = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall_i) begin
                        if (q.bitcnt == 4'd7) begin
                            n.oe    = 1'b0;
                            n.state = S_TX_ACK;
                        end else begin
                            n.bitcnt = q.bitcnt + 4'd1;
                            n.txbyte = {q.txbyte[6:0], 1'b0};
                            n.oe     = ~q.txbyte[6];
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise_i) begin
                        n.ackd = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (q.ackd && int'(q.idx) < int'(lim)) begin
                            n.state  = S_TX;
                            n.txbyte = rd_data_i;
                            n.oe     = ~rd_data_i[7];
                            n.idx    = q.idx + 1'b1;
                            n.bitcnt = '0;
                        end else begin
                            n.state = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.phase <= PH_ADDR;
        end else begin
            q <= n;
        end
    end

    assign rd_idx_o  = q.idx;
    assign wr_idx_o  = q.idx;
    assign wr_data_o = q.shreg;
    assign wr_en_o   = wr_en;
    assign sda_oe_o  = q.oe;

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
    parameter int         NREG     = 21,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         CNT_IDX  = 8,
    parameter int         PAIR0_LO = 11,
    parameter int         PAIR1_LO = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int IDX_W = $clog2(NREG + 1);

    logic             scl_lvl_w, sda_lvl_w, scl_rise_w, scl_fall_w;
    logic             start_w, stop_w;
    logic             wr_en_w;
    logic [IDX_W-1:0] wr_idx_w, rd_idx_w;
    logic [7:0]       wr_data_w, rd_data_w, cnt_val_w;

    i2c_line_sampler i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl_w),
        .sda_lvl_o  (sda_lvl_w),
        .scl_rise_o (scl_rise_w),
        .scl_fall_o (scl_fall_w),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2c_blk_engine #(
        .NREG     (NREG),
        .IDX_W    (IDX_W),
        .DEV_ADDR (DEV_ADDR)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise_w),
        .scl_fall_i (scl_fall_w),
        .sda_lvl_i  (sda_lvl_w),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .cnt_val_i  (cnt_val_w),
        .rd_data_i  (rd_data_w),
        .rd_idx_o   (rd_idx_w),
        .wr_en_o    (wr_en_w),
        .wr_idx_o   (wr_idx_w),
        .wr_data_o  (wr_data_w),
        .sda_oe_o   (sda_oe_o)
    );

    cfg_reg_store #(
        .NREG     (NREG),
        .IDX_W    (IDX_W),
        .CNT_IDX  (CNT_IDX),
        .PAIR0_LO (PAIR0_LO),
        .PAIR1_LO (PAIR1_LO)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .stop_i    (stop_w),
        .wr_en_i   (wr_en_w),
        .wr_idx_i  (wr_idx_w),
        .wr_data_i (wr_data_w),
        .rd_idx_i  (rd_idx_w),
        .rd_data_o (rd_data_w),
        .cnt_val_o (cnt_val_w),
        .cfg_o     (cfg_o)
    );

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
    parameter int NREG     = 21,
    parameter int CNT_IDX  = 8,
    parameter int PAIR0_LO = 11,
    parameter int PAIR1_LO = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              stop_evt,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg
);

    assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    assert_oe_fall_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_lvl);

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    assert_count_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[CNT_IDX*8 +: 8] != 8'h00);

    assert_pair0_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg[PAIR0_LO*8 +: 16]) |-> $past(stop_evt));

    assert_pair1_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg[PAIR1_LO*8 +: 16]) |-> $past(stop_evt));

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(
    .NREG     (NREG),
    .CNT_IDX  (CNT_IDX),
    .PAIR0_LO (PAIR0_LO),
    .PAIR1_LO (PAIR1_LO)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl_w),
    .stop_evt (stop_w),
    .sda_oe   (sda_oe_o),
    .cfg      (cfg_o)
);

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;

    localparam int NREG = 21;
    localparam int Q    = 10;   // quarter SCL period in system clocks

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_oe;
    logic [NREG*8-1:0] cfg;
    logic              sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    cfg_i2c_slave i_cfg_i2c_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .cfg_o    (cfg)
    );

    int         tests = 0;
    int         fails = 0;
    int         mon_err = 0;
    int         r11_err = 0;
    logic       mon_en = 1'b0;
    logic       prev_oe = 1'b0;
    logic       prev_scl = 1'b1;
    logic [7:0] model [NREG];
    logic [7:0] txq [$];

    task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] dflt(input int i);
        if (i == 8) return 8'h08;
        if (i == 9) return 8'h10;
        if (i == 6) return 8'h07;
        if ((i >= 1 && i <= 5) || i == 15 || i == 16) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    function automatic logic [7:0] reg_at(input int i);
        return cfg[i*8 +: 8];
    endfunction

    // every-clock comparison with the model between transactions; R11 watch
    always @(negedge clk) begin
        if (mon_en && cfg !== model_flat()) mon_err++;
        if (rst_n && scl && prev_scl && sda_oe !== prev_oe) r11_err++;
        prev_oe  = sda_oe;
        prev_scl = scl;
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        mon_en = 1'b0;
        sda_m = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        sda_m = 1'b0; wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_q();
        scl = 1'b1;   wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl = 1'b1;   wait_q(); wait_q();
            scl = 1'b0;   wait_q();
        end
        sda_m = 1'b1; wait_q();
        scl = 1'b1;   wait_q();
        ack = (sda_line == 1'b0);
        wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            scl = 1'b1; wait_q();
            b[i] = sda_line;
            wait_q();
            scl = 1'b0;
        end
        wait_q();
        sda_m = ~ack_it; wait_q();
        scl = 1'b1;      wait_q(); wait_q();
        scl = 1'b0;      wait_q();
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [7:0] addr, input logic do_stop, output int nacks);
        logic a;
        nacks = 0;
        i2c_start();
        send_byte(addr, a);  if (!a) nacks++;
        send_byte(8'h55, a); if (!a) nacks++;
        send_byte(8'h03, a); if (!a) nacks++;
        foreach (txq[k]) begin
            send_byte(txq[k], a);
            if (!a) nacks++;
        end
        if (do_stop) i2c_stop();
    endtask

    // behavioural model of one accepted write transaction
    task automatic model_apply();
        logic [7:0] sh [4];
        logic       pd [4];
        for (int j = 0; j < 4; j++) pd[j] = 1'b0;
        foreach (txq[k]) begin
            if (k >= 11 && k <= 14) begin
                sh[k-11] = txq[k];
                pd[k-11] = 1'b1;
            end else if (k < NREG && !(k == 8 && txq[k] == 8'h00)) begin
                model[k] = txq[k];
            end
        end
        if (pd[0] && pd[1]) begin model[11] = sh[0]; model[12] = sh[1]; end
        if (pd[2] && pd[3]) begin model[13] = sh[2]; model[14] = sh[3]; end
    endtask

    task automatic settle(input string req);
        repeat (8) @(negedge clk);
        check(req, cfg === model_flat(), 32'(cfg[31:0]), 32'(model_flat() >> 0));
        check("R11 released after stop", sda_oe == 1'b0, 32'(sda_oe), 0);
        mon_en = 1'b1;
    endtask

    task automatic load_count(input logic [7:0] c);
        int nk;
        txq = {};
        for (int k = 0; k < 9; k++) txq.push_back(k == 8 ? c : 8'h60 + 8'(k));
        wr_txn(8'hD2, 1'b1, nk);
        check("R2 R3 count load acks", nk == 0, nk, 0);
        model_apply();
        settle("R3 count load registers");
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int         nk;
        logic       a;
        logic [7:0] b;

        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        for (int i = 0; i < NREG; i++)
            check("R1 reset value", reg_at(i) === dflt(i), reg_at(i), dflt(i));
        check("R1 sda released", sda_oe === 1'b0, 32'(sda_oe), 0);
        mon_en = 1'b1;

        // R3/R4 full block past the end
        txq = {};
        for (int k = 0; k < 23; k++) txq.push_back(8'h20 + 8'(k * 7));
        wr_txn(8'hD2, 1'b1, nk);
        check("R2 R3 R4 all bytes acked", nk == 0, nk, 0);
        model_apply();
        settle("R3 full block registers");
        check("R4 no wrap to register 0", reg_at(0) === 8'h20, reg_at(0), 8'h20);
        check("R5 pair 11 committed", reg_at(11) === 8'h20 + 8'(77), reg_at(11), 8'h20 + 8'(77));
        check("R6 pair 13 committed", reg_at(14) === 8'h20 + 8'(98), reg_at(14), 8'h20 + 8'(98));

        // R5/R6 partial: registers 0..13
        txq = {};
        for (int k = 0; k < 14; k++) txq.push_back(8'hA0 + 8'(k));
        wr_txn(8'hD2, 1'b0, nk);
        repeat (4) @(negedge clk);
        check("R5 pair held before stop", reg_at(11) === model[11], reg_at(11), model[11]);
        check("R3 plain register live before stop", reg_at(10) === 8'hAA, reg_at(10), 8'hAA);
        i2c_stop();
        model_apply();
        settle("R5 R6 partial block registers");
        check("R5 pair 11 after stop", reg_at(11) === 8'hAB, reg_at(11), 8'hAB);
        check("R6 lone 13 not loaded", reg_at(13) === 8'h20 + 8'(91), reg_at(13), 8'h20 + 8'(91));

        // R2 foreign address
        txq = {8'h11, 8'h22};
        wr_txn(8'hA4, 1'b1, nk);
        check("R2 foreign address never acked", nk == 5, nk, 5);
        settle("R2 foreign address no change");

        // R7 zero into count register
        txq = {};
        for (int k = 0; k < 9; k++) txq.push_back(k == 8 ? 8'h00 : 8'h40 + 8'(k));
        wr_txn(8'hD2, 1'b1, nk);
        model_apply();
        settle("R7 zero write");
        check("R7 count kept", reg_at(8) === 8'hA8, reg_at(8), 8'hA8);
        check("R3 register 7 written", reg_at(7) === 8'h47, reg_at(7), 8'h47);

        // R8/R9 short read with ACK to the end
        load_count(8'h05);
        i2c_start();
        send_byte(8'hD3, a);
        check("R2 read address acked", a === 1'b1, 32'(a), 1);
        recv_byte(1'b1, b);
        check("R8 count byte first", b === 8'h05, b, 8'h05);
        for (int i = 0; i < 5; i++) begin
            recv_byte(1'b1, b);
            check("R8 register readback", b === model[i], b, model[i]);
        end
        recv_byte(1'b0, b);
        check("R9 released after count", b === 8'hFF, b, 8'hFF);
        i2c_stop();
        settle("R9 read leaves registers");

        // R10 early NACK
        i2c_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, b);
        recv_byte(1'b1, b);
        check("R10 register 0 before nack", b === model[0], b, model[0]);
        recv_byte(1'b0, b);
        check("R10 register 1 with nack", b === model[1], b, model[1]);
        recv_byte(1'b0, b);
        check("R10 released after nack", b === 8'hFF, b, 8'hFF);
        i2c_stop();
        settle("R10 read leaves registers");

        // R9 count above file size
        load_count(8'h1E);
        i2c_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, b);
        check("R8 large count byte", b === 8'h1E, b, 8'h1E);
        for (int i = 0; i < NREG; i++) begin
            recv_byte(1'b1, b);
            check("R9 clamped readback", b === model[i], b, model[i]);
        end
        recv_byte(1'b0, b);
        check("R9 released at file end", b === 8'hFF, b, 8'hFF);
        i2c_stop();
        settle("R9 clamp leaves registers");

        check("R3 R5 monitor between transactions", mon_err == 0, mon_err, 0);
        check("R11 sda_oe steady while scl high", r11_err == 0, r11_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule